// File: doc/BRIEF.md
# Linked-Descriptor SD Card DMA Engine

This block moves data between system memory and an SD card data stream without processor help for each word. Software places a chain of descriptors in memory. Each descriptor is four 32-bit words. The engine reads them one after another from a programmed base address. For each descriptor it fetches the four words and limits the buffer length to the size the build supports. It then streams 32-bit words between the buffer and the card. When the buffer is done, it writes the descriptor status word back with the ownership flag cleared. It follows the next pointer until it has finished a descriptor flagged as the final one, or until the programmed byte count runs out.

A transfer starts with a one-cycle `start` pulse. At that moment the engine must be enabled and the byte count and block size must both be non-zero. When the transfer finishes, the engine gives a one-cycle `xfer_done` pulse. The command logic uses this pulse to raise its data-complete and card-interrupt flags. The engine also sets a summary flag and a direction flag in its own status register, which software clears by writing ones. The remaining byte count is output after every word, so the command logic can keep its own counter in step and decide when to issue an automatic stop.

Top module: `sd_desc_dma`

## Requirements
- R1: Descriptor words are fetched from the descriptor address at offsets +0, +4, +8 and +12, in that order. The four words are, in order: status, buffer size in bytes, buffer address, next-descriptor address.
- R2: A buffer size of 0 means the maximum buffer size. A size above the maximum is reduced to the maximum. The maximum is 8192 bytes when `LARGE_BUFFERS` is 0 and 65536 bytes when it is 1.
- R3: Bits 1:0 of the buffer address are ignored. Word k of a buffer is at (address with bits 1:0 cleared) + 4·k.
- R4: Each descriptor moves the smaller of its limited size and the remaining byte count. `rem_bytes` is loaded with `byte_count` at start and drops by the bytes moved with each word.
- R5: After its data, each descriptor's status word is written back to its own address with bit 31 (hold) cleared and all other bits unchanged.
- R6: The engine continues at the next-descriptor address. It stops after the descriptor whose status bit 2 (last) is set, or as soon as `rem_bytes` reaches 0. A descriptor that is not reached is not modified.
- R7: A `start` pulse is ignored in any of these cases: `dma_en` is 0, `byte_count` is 0, `block_size` is 0, or a transfer is already running.
- R8: A card-to-memory transfer (`to_card` = 0) waits after start, without any memory access, until `card_rx_ready` is 1.
- R9: When a transfer ends, `xfer_done` pulses for one cycle. In the next cycle `dma_status` has bit 8 (summary) set, plus bit 0 for memory-to-card or bit 1 for card-to-memory. All status bits are 0 after reset.
- R10: A `sts_wr` cycle clears each bit of `dma_status` whose bit in `sts_wdata` is 1 and leaves the other bits unchanged. A completion in the same cycle takes priority over the clear.
- R11: A memory request holds its address, direction and write data until `mem_ack`. A card word on the transmit stream holds its data until `tx_ready`. No word is lost or repeated while either side stalls.
- R12: At most `BURST_BYTES`/4 data words (256 by default) move in a row. After that the engine spends one cycle with no memory or card request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | DMA enable from global control |
| to_card | input | 1 | 1: memory to card (transmit), 0: card to memory (receive) |
| desc_base | input | 32 | Address of the first descriptor |
| byte_count | input | 32 | Total bytes to move |
| block_size | input | 32 | Card block size; 0 blocks a start |
| start | input | 1 | One-cycle command pulse |
| card_rx_ready | input | 1 | Card has receive data pending |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 32 | Transmit word |
| tx_ready | input | 1 | Card accepts transmit word |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 32 | Receive word |
| rx_ready | output | 1 | Engine accepts receive word |
| sts_wr | input | 1 | Status clear strobe |
| sts_wdata | input | 10 | Status bits to clear |
| dma_status | output | 10 | Summary (8), receive (1), transmit (0) |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | Transfer in progress |
| rem_bytes | output | 32 | Bytes still to move |

## Verification
The bench drives every input on the falling edge and reads every output on the falling edge after it. A request or word that is valid and acknowledged at a falling edge is taken at the next rising edge, and it is scored at that falling edge. The effect of a start or a status clear is visible at the first falling edge after the rising edge that takes it. The `dma_status` flags are checked one falling edge after the edge where `xfer_done` is seen, because they are registered from the finishing state. Descriptor write-back and receive buffer contents are read from the bench memory model only after `xfer_done`. By then every write handshake has completed.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned STS_W      = 10;
  localparam int unsigned HOLD_BIT   = 31;
  localparam int unsigned LAST_BIT   = 2;
  localparam int unsigned SUM_BIT    = 8;
  localparam int unsigned RXF_BIT    = 1;
  localparam int unsigned TXF_BIT    = 0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT_CARD, ST_FETCH, ST_SETUP, ST_RD, ST_TX,
    ST_RX, ST_WR, ST_GAP, ST_WB, ST_FINISH
  } dma_state_e;

  // zero or oversize selects the build maximum
  function automatic logic [31:0] sdd_clamp(input logic [31:0] raw, input logic [31:0] max_b);
    return (raw == 32'd0 || raw > max_b) ? max_b : raw;
  endfunction

  function automatic logic [31:0] sdd_min(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  // bytes credited for one word move
  function automatic logic [31:0] sdd_step(input logic [31:0] left);
    return (left >= WORD_BYTES) ? WORD_BYTES : left;
  endfunction

  function automatic logic [31:0] sdd_buf_addr(input logic [31:0] base, input logic [31:0] off);
    return {base[31:2], 2'b00} + off;
  endfunction
endpackage

// File: rtl/sdd_byte_track.sv
module sdd_byte_track
  import sdd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_total,
  input  logic [31:0] total,
  input  logic        load_desc,
  input  logic [31:0] desc_limit,
  input  logic        step_en,
  output logic [31:0] rem,
  output logic [31:0] desc_left,
  output logic        last_word
);
  logic [31:0] step;
  assign step      = sdd_step(desc_left);
  assign last_word = (desc_left <= WORD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem       <= '0;
      desc_left <= '0;
    end else begin
      if (load_total)   rem <= total;
      else if (step_en) rem <= rem - step;
      if (load_desc)    desc_left <= sdd_min(desc_limit, rem);
      else if (step_en) desc_left <= desc_left - step;
    end
  end
endmodule

// File: rtl/sdd_burst.sv
module sdd_burst #(
  parameter int unsigned BURST_WORDS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic word_done,
  output logic full
);
  localparam int unsigned CW = $clog2(BURST_WORDS + 1);
  logic [CW-1:0] cnt;

  assign full = (cnt == CW'(BURST_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clear)     cnt <= '0;
    else if (word_done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdd_dma_status.sv
module sdd_dma_status
  import sdd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_tx,
  input  logic             set_rx,
  input  logic             clr_en,
  input  logic [STS_W-1:0] clr_bits,
  output logic [STS_W-1:0] sts
);
  logic [STS_W-1:0] clr_mask, set_mask;

  assign clr_mask = clr_en ? clr_bits : '0;
  assign set_mask = (set_tx ? (STS_W'(1) << TXF_BIT) : '0)
                  | (set_rx ? (STS_W'(1) << RXF_BIT) : '0)
                  | ((set_tx | set_rx) ? (STS_W'(1) << SUM_BIT) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/sd_desc_dma.sv
module sd_desc_dma
  import sdd_pkg::*;
#(
  parameter bit          LARGE_BUFFERS = 1'b0,
  parameter int unsigned BURST_BYTES   = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_en,
  input  logic             to_card,
  input  logic [31:0]      desc_base,
  input  logic [31:0]      byte_count,
  input  logic [31:0]      block_size,
  input  logic             start,
  input  logic             card_rx_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             tx_valid,
  output logic [31:0]      tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [31:0]      rx_data,
  output logic             rx_ready,
  input  logic             sts_wr,
  input  logic [STS_W-1:0] sts_wdata,
  output logic [STS_W-1:0] dma_status,
  output logic             xfer_done,
  output logic             busy,
  output logic [31:0]      rem_bytes
);
  localparam logic [31:0] MAX_DESC    = LARGE_BUFFERS ? 32'd65536 : 32'd8192;
  localparam int unsigned BURST_WORDS = BURST_BYTES / WORD_BYTES;
  localparam int unsigned IDX_W       = $clog2(DESC_WORDS);

  dma_state_e        state, state_n;
  logic [31:0]       desc_w [DESC_WORDS];
  logic [31:0]       desc_ptr, buf_off, data_hold;
  logic [IDX_W-1:0]  widx;
  logic              dir_tx;

  // named events for the checker
  logic accept, fetch_ack, rd_ack, wr_ack, wb_ack, tx_fire, rx_fire, word_done;
  logic wb_phase, burst_full, last_word, desc_is_last;
  logic [31:0] desc_left, desc_limit;

  assign accept    = (state == ST_IDLE) && start && dma_en
                   && (byte_count != 32'd0) && (block_size != 32'd0);
  assign fetch_ack = (state == ST_FETCH) && mem_ack;
  assign rd_ack    = (state == ST_RD) && mem_ack;
  assign wr_ack    = (state == ST_WR) && mem_ack;
  assign wb_ack    = (state == ST_WB) && mem_ack;
  assign tx_fire   = (state == ST_TX) && tx_ready;
  assign rx_fire   = (state == ST_RX) && rx_valid;
  assign word_done = tx_fire || wr_ack;
  assign wb_phase  = (state == ST_WB);
  assign desc_is_last = desc_w[0][LAST_BIT];
  assign desc_limit   = sdd_clamp(desc_w[1], MAX_DESC);

  assign busy      = (state != ST_IDLE);
  assign xfer_done = (state == ST_FINISH);
  assign tx_valid  = (state == ST_TX);
  assign tx_data   = data_hold;
  assign rx_ready  = (state == ST_RX);

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_ptr + {28'd0, widx, 2'b00};
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = sdd_buf_addr(desc_w[2], buf_off);
      end
      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sdd_buf_addr(desc_w[2], buf_off);
        mem_wdata = data_hold;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_ptr;
        mem_wdata = desc_w[0] & ~(32'd1 << HOLD_BIT);
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:      if (accept) state_n = to_card ? ST_FETCH : ST_WAIT_CARD;
      ST_WAIT_CARD: if (card_rx_ready) state_n = ST_FETCH;
      ST_FETCH:     if (fetch_ack && widx == IDX_W'(DESC_WORDS - 1)) state_n = ST_SETUP;
      ST_SETUP:     state_n = dir_tx ? ST_RD : ST_RX;
      ST_RD:        if (rd_ack) state_n = ST_TX;
      ST_RX:        if (rx_fire) state_n = ST_WR;
      ST_TX, ST_WR: begin
        if (word_done) begin
          if (last_word)       state_n = ST_WB;
          else if (burst_full) state_n = ST_GAP;
          else                 state_n = dir_tx ? ST_RD : ST_RX;
        end
      end
      ST_GAP:       state_n = dir_tx ? ST_RD : ST_RX;
      ST_WB:        if (wb_ack) state_n = (desc_is_last || rem_bytes == 32'd0) ? ST_FINISH : ST_FETCH;
      ST_FINISH:    state_n = ST_IDLE;
      default:      state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      desc_ptr  <= '0;
      buf_off   <= '0;
      data_hold <= '0;
      widx      <= '0;
      dir_tx    <= 1'b0;
    end else begin
      state <= state_n;
      if (accept) begin
        desc_ptr <= desc_base;
        dir_tx   <= to_card;
        widx     <= '0;
      end
      if (fetch_ack) widx <= widx + 1'b1;
      if (state == ST_SETUP) buf_off <= '0;
      else if (word_done)    buf_off <= buf_off + WORD_BYTES;
      if (rd_ack)  data_hold <= mem_rdata;
      if (rx_fire) data_hold <= rx_data;
      if (wb_ack)  desc_ptr  <= desc_w[3];
    end
  end

  // descriptor word capture, one register per word
  for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_desc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) desc_w[gi] <= '0;
      else if (fetch_ack && widx == IDX_W'(gi)) desc_w[gi] <= mem_rdata;
    end
  end

  sdd_byte_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_total (accept),
    .total      (byte_count),
    .load_desc  (state == ST_SETUP),
    .desc_limit (desc_limit),
    .step_en    (word_done),
    .rem        (rem_bytes),
    .desc_left  (desc_left),
    .last_word  (last_word)
  );

  sdd_burst #(.BURST_WORDS(BURST_WORDS)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (state == ST_SETUP || state == ST_GAP),
    .word_done (word_done),
    .full      (burst_full)
  );

  sdd_dma_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_tx   (xfer_done && dir_tx),
    .set_rx   (xfer_done && !dir_tx),
    .clr_en   (sts_wr),
    .clr_bits (sts_wdata),
    .sts      (dma_status)
  );
endmodule

// File: rtl/sdd_checks.sv
module sdd_checks #(
  parameter int unsigned BURST_WORDS = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        dma_en,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic        rx_ready,
  input logic        xfer_done,
  input logic [9:0]  dma_status,
  input logic [31:0] rem_bytes,
  input logic        word_done,
  input logic        wb_phase
);
  logic [31:0] run_cnt;
  logic        idle_gap;
  assign idle_gap = busy && !mem_req && !tx_valid && !rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt <= '0;
    else if (idle_gap)  run_cnt <= '0;
    else if (word_done) run_cnt <= run_cnt + 32'd1;
  end

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_dir_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  p_wb_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_phase && mem_req |-> mem_we && !mem_wdata[31]);

  p_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !dma_en |=> !busy);

  p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> dma_status[8] && (dma_status[0] || dma_status[1]));

  p_rem_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> rem_bytes <= $past(rem_bytes));

  p_burst_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 32'(BURST_WORDS));
endmodule

bind sd_desc_dma sdd_checks #(.BURST_WORDS(BURST_WORDS)) u_sdd_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .dma_en     (dma_en),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .rx_ready   (rx_ready),
  .xfer_done  (xfer_done),
  .dma_status (dma_status),
  .rem_bytes  (rem_bytes),
  .word_done  (word_done),
  .wb_phase   (wb_phase)
);

// File: tb/tb_sd_desc_dma.sv
module tb_sd_desc_dma;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HOLD = 32'h8000_0000;
  localparam logic [31:0] CHN  = 32'h10;
  localparam logic [31:0] FST  = 32'h08;
  localparam logic [31:0] LST  = 32'h04;

  logic clk = 0, rst_n = 0;
  logic dma_en = 0, to_card = 0, start = 0, card_rx_ready = 0;
  logic [31:0] desc_base = 0, byte_count = 0, block_size = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic [31:0] tx_data, rx_data = 0;
  logic sts_wr = 0;
  logic [9:0] sts_wdata = 0, dma_status;
  logic xfer_done, busy;
  logic [31:0] rem_bytes;

  sd_desc_dma dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] exp_q [$];
  logic [31:0] rx_q [$];
  bit mem_stall = 0, tx_stall = 0, rx_stall = 0, rx_take = 0, mem_seen = 0;
  int cyc = 0, run = 0, max_run = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return (a * 32'h0100_0193) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, st, sz, ad, nx);
    mem[a] = st; mem[a+4] = sz; mem[a+8] = ad; mem[a+12] = nx;
  endtask

  // scoreboard driver: expected card words for one buffer chunk
  task automatic expect_tx(input logic [31:0] ad, input int nbytes);
    for (int i = 0; i < nbytes / 4; i++) exp_q.push_back(rd({ad[31:2], 2'b00} + 32'(4 * i)));
  endtask

  // memory, card and burst monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mem_ack = 0; tx_ready = 0; rx_valid = 0; rx_take = 0;
    end else begin
      if (mem_req) mem_seen = 1;
      if (mem_req && !mem_ack && !(mem_stall && cyc % 3 == 0)) begin
        mem_ack = 1;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else        mem_rdata = rd(mem_addr);
      end else mem_ack = 0;

      tx_ready = !(tx_stall && cyc % 4 == 1);
      if (tx_valid && tx_ready) begin
        run++;
        if (exp_q.size() == 0) check(0, "R1/R4 unexpected tx word", tx_data, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(tx_data == e, "R1/R3/R11 tx word", tx_data, e);
        end
      end

      if (rx_take) void'(rx_q.pop_front());
      rx_valid = (rx_q.size() > 0) && !(rx_stall && cyc % 5 == 2);
      rx_data  = rx_valid ? rx_q[0] : 32'd0;
      rx_take  = rx_valid && rx_ready;
      if (rx_take) run++;

      if (busy && !mem_req && !tx_valid && !rx_ready) begin
        if (run > max_run) max_run = run;
        run = 0;
      end
    end
  end

  task automatic kick(input logic [31:0] base, cnt, bsz, input logic wr);
    @(negedge clk);
    desc_base = base; byte_count = cnt; block_size = bsz; to_card = wr; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input int limit, output bit got);
    got = 0;
    for (int i = 0; i < limit && !got; i++) begin
      if (xfer_done) got = 1;
      else @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic sts_clear(input logic [9:0] v);
    @(negedge clk); sts_wr = 1; sts_wdata = v;
    @(negedge clk); sts_wr = 0; sts_wdata = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(dma_status == 0, "R9 reset status", 32'(dma_status), 0);
    check(!busy && !xfer_done && !mem_req, "R9 reset idle", {busy, xfer_done, mem_req}, 0);
    check(rem_bytes == 0, "R4 reset remaining", rem_bytes, 0);

    // chained transmit with stalls on both sides
    dma_en = 1; mem_stall = 1; tx_stall = 1;
    put_desc(32'h100, HOLD | FST | CHN, 16, 32'h1001, 32'h200);
    put_desc(32'h200, HOLD | CHN,       24, 32'h2002, 32'h300);
    put_desc(32'h300, HOLD | CHN | LST, 40, 32'h3000, 32'hDEAD_0000);
    expect_tx(32'h1000, 16); expect_tx(32'h2000, 24); expect_tx(32'h3000, 24);
    kick(32'h100, 64, 512, 1);
    wait_done(5000, got);
    check(got, "R6 chain completes", 32'(got), 1);
    check(exp_q.size() == 0, "R4 chain words all moved", exp_q.size(), 0);
    check(rem_bytes == 0, "R4 remaining after chain", rem_bytes, 0);
    check(mem[32'h100] == (FST | CHN), "R5 writeback first", mem[32'h100], FST | CHN);
    check(mem[32'h200] == CHN, "R5 writeback middle", mem[32'h200], CHN);
    check(mem[32'h300] == (CHN | LST), "R5 R6 writeback last", mem[32'h300], CHN | LST);
    check(dma_status == 10'h101, "R9 transmit flags", 32'(dma_status), 32'h101);

    // write-one-to-clear
    sts_clear(10'h001);
    check(dma_status == 10'h100, "R10 clear transmit flag", 32'(dma_status), 32'h100);
    sts_clear(10'h200);
    check(dma_status == 10'h100, "R10 zero bits keep", 32'(dma_status), 32'h100);
    sts_clear(10'h100);
    check(dma_status == 10'h000, "R10 clear summary", 32'(dma_status), 0);

    // starts that must be ignored
    mem_stall = 0; tx_stall = 0;
    dma_en = 0; mem_seen = 0;
    kick(32'h100, 64, 512, 1);
    repeat (20) @(negedge clk);
    check(!busy && !mem_seen, "R7 disabled start ignored", {busy, mem_seen}, 0);
    dma_en = 1;
    kick(32'h100, 64, 0, 1);
    repeat (20) @(negedge clk);
    check(!busy && !mem_seen, "R7 zero block size ignored", {busy, mem_seen}, 0);
    kick(32'h100, 0, 512, 1);
    repeat (20) @(negedge clk);
    check(!busy && !mem_seen && dma_status == 0, "R7 zero byte count ignored",
          {busy, mem_seen, 1'b0}, 0);

    // receive waits for card data
    rx_stall = 1; card_rx_ready = 0;
    put_desc(32'h400, HOLD | FST | LST, 32, 32'h5003, 0);
    for (int i = 0; i < 8; i++) rx_q.push_back(32'hC0DE_0000 + 32'(i * 17));
    kick(32'h400, 32, 512, 0);
    mem_seen = 0;
    repeat (15) @(negedge clk);
    check(busy && !mem_seen, "R8 receive waits for card", {busy, mem_seen}, 32'b10);
    check(rx_q.size() == 8, "R8 no card word taken", rx_q.size(), 8);
    card_rx_ready = 1;
    wait_done(5000, got);
    check(got, "R8 receive completes", 32'(got), 1);
    for (int i = 0; i < 8; i++)
      check(rd(32'h5000 + 32'(4 * i)) == 32'hC0DE_0000 + 32'(i * 17), "R3 R4 receive buffer",
            rd(32'h5000 + 32'(4 * i)), 32'hC0DE_0000 + 32'(i * 17));
    check(mem[32'h400] == (FST | LST), "R5 receive writeback", mem[32'h400], FST | LST);
    check(dma_status == 10'h102, "R9 receive flags", 32'(dma_status), 32'h102);
    sts_clear(10'h3FF);
    rx_stall = 0; card_rx_ready = 0;

    // oversize clamp and burst length
    put_desc(32'h600, HOLD | LST, 32'h3000, 32'h1_0000, 0);
    expect_tx(32'h1_0000, 8192);
    max_run = 0; run = 0;
    kick(32'h600, 32'h2800, 512, 1);
    wait_done(40000, got);
    check(got && exp_q.size() == 0, "R2 oversize moves max", exp_q.size(), 0);
    check(rem_bytes == 32'h800, "R2 oversize remaining", rem_bytes, 32'h800);
    check(max_run == 256, "R12 burst length", max_run, 256);

    // size zero means maximum
    put_desc(32'h700, HOLD | LST, 0, 32'h2_0000, 0);
    expect_tx(32'h2_0000, 8192);
    kick(32'h700, 32'h2100, 512, 1);
    wait_done(40000, got);
    check(got && exp_q.size() == 0, "R2 zero size moves max", exp_q.size(), 0);
    check(rem_bytes == 32'h100, "R2 zero size remaining", rem_bytes, 32'h100);

    // count runs out before the last flag
    put_desc(32'h800, HOLD | CHN, 64, 32'h3_0000, 32'h900);
    put_desc(32'h900, HOLD | LST, 64, 32'h3_1000, 0);
    expect_tx(32'h3_0000, 32);
    kick(32'h800, 32, 512, 1);
    wait_done(5000, got);
    check(got && exp_q.size() == 0, "R4 R6 short count", exp_q.size(), 0);
    check(mem[32'h800] == CHN, "R5 first released", mem[32'h800], CHN);
    check(mem[32'h900] == (HOLD | LST), "R6 unreached untouched", mem[32'h900], HOLD | LST);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule